// File: doc/BRIEF.md
# Key-Locked Add/Subtract/Compare Datapath

This block is a combinational arithmetic unit that returns the sum, the difference, an unsigned less-than flag and an equality flag of two operands. Some internal wires of the unit pass through key gates. Each key gate is fed by one bit of a 64-bit key bus. The results are correct only when the key bus carries the one key value fixed at synthesis time. With any other key the part gives wrong answers, so it fails its normal production test until the right key is loaded.

Each key gate sits on the propagate wire that feeds the last XOR of one result bit. The carry chain reads its own copy of that wire, which has no gate on it. A gate is an XOR where its designated key bit is 0 and an XNOR where that bit is 1. As a result, each locked wire reaches exactly one output bit, and no other locked wire reaches that bit. A wrong key bit therefore inverts its own output bit for every operand, and two wrong bits can never cancel each other. The comparator flags are never locked.

The block also holds an unlocked reference copy of the same function, driven onto separate ports, so that the locked and reference results can be compared directly. An elaboration-time check rejects a key narrower than 64 bits, a key wider than the number of result bits, and a key too short to cover the adder.

Top module: `xor_locked_dp`

## Requirements
- R1: When `key_i` equals `CORRECT_KEY`, `sum_o` = a+b (W+1 bits), `diff_o` = a-b modulo 2^W, `lt_o` = (a<b, unsigned) and `eq_o` = (a==b), for every pair of operands.
- R2: Key bit j, for j in 0..W (0..32 by default), controls sum bit j only. When that key bit differs from the correct key, `sum_o[j]` is inverted for every operand.
- R3: Key bit W+1+k, for k in 0..KEY_W-W-2 (bits 33..63 by default), controls difference bit k only. When that key bit is wrong, `diff_o[k]` is inverted. The difference bits above the locked range, which is bit 31 by default, never depend on the key.
- R4: `lt_o` and `eq_o` do not depend on the key.
- R5: `ref_sum_o`, `ref_diff_o`, `ref_lt_o` and `ref_eq_o` always give the correct function, whatever key is applied.
- R6: When several key bits are wrong at once, the XOR of the locked and the correct results is exactly the set of wrong key bits, mapped as in R2 and R3. Wrong bits never cancel each other.
- R7: Every key other than `CORRECT_KEY` corrupts at least one result bit on any operand pair, so the correct key is the only key that works.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| key_i | input | KEY_W | Key bus that drives the key gates |
| sum_o | output | W+1 | Locked sum, including the carry out |
| diff_o | output | W | Locked difference a-b |
| lt_o | output | 1 | Unsigned a<b |
| eq_o | output | 1 | a==b |
| ref_sum_o | output | W+1 | Reference sum |
| ref_diff_o | output | W | Reference difference |
| ref_lt_o | output | 1 | Reference less-than |
| ref_eq_o | output | 1 | Reference equality |

## Verification
A key gate that is missing, placed on the wrong wire or given the wrong polarity shows up at once, in the same evaluation, as a fixed inverted bit in `sum_o` or `diff_o` compared with the reference ports. A gate that leaked into the carry chain would instead corrupt higher result bits only for some operands. For that reason each single-bit key flip is applied over several random operand pairs, and the whole mismatch pattern is compared, not just whether a mismatch exists. Random multi-bit keys check that the wrong bits never cancel.

// File: rtl/dp_lock_pkg.sv
package dp_lock_pkg;
  typedef enum logic {GATE_XOR = 1'b0, GATE_XNOR = 1'b1} gate_kind_e;

  // gate polarity chosen so the designated key bit passes the wire unchanged
  function automatic gate_kind_e gate_for(input logic good_bit);
    return good_bit ? GATE_XNOR : GATE_XOR;
  endfunction
endpackage

// File: rtl/dp_key_gate.sv
module dp_key_gate
  import dp_lock_pkg::*;
#(
  parameter logic GOOD = 1'b0
) (
  input  logic wire_i,
  input  logic key_i,
  output logic wire_o
);
  localparam gate_kind_e KIND = gate_for(GOOD);

  if (KIND == GATE_XNOR) begin : g_xnor
    assign wire_o = ~(wire_i ^ key_i);
  end else begin : g_xor
    assign wire_o = wire_i ^ key_i;
  end
endmodule

// File: rtl/dp_locked_addsub.sv
module dp_locked_addsub #(
  parameter int                W        = 32,
  parameter int                N_LOCK   = 33,
  parameter logic              SUB      = 1'b0,
  parameter logic [N_LOCK-1:0] GOOD_KEY = '0
) (
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic [N_LOCK-1:0] key_i,
  output logic [W-1:0]      res_o,
  output logic              cout_o
);
  logic [W-1:0] bb, p, g, p_res;
  logic [W:0]   c;

  assign bb   = SUB ? ~b_i : b_i;
  assign p    = a_i ^ bb;
  assign g    = a_i & bb;
  assign c[0] = SUB;

  for (genvar i = 0; i < W; i++) begin : g_bit
    // carry chain uses the ungated propagate, so a lock stays private to one bit
    assign c[i+1] = g[i] | (p[i] & c[i]);
    if (i < N_LOCK) begin : g_lock
      dp_key_gate #(.GOOD(GOOD_KEY[i])) u_gate (
        .wire_i(p[i]), .key_i(key_i[i]), .wire_o(p_res[i])
      );
    end else begin : g_open
      assign p_res[i] = p[i];
    end
    assign res_o[i] = p_res[i] ^ c[i];
  end

  if (N_LOCK > W) begin : g_cout_lock
    dp_key_gate #(.GOOD(GOOD_KEY[W])) u_gate (
      .wire_i(c[W]), .key_i(key_i[W]), .wire_o(cout_o)
    );
  end else begin : g_cout_open
    assign cout_o = c[W];
  end
endmodule

// File: rtl/dp_ref.sv
module dp_ref #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W:0]   sum_o,
  output logic [W-1:0] diff_o,
  output logic         lt_o,
  output logic         eq_o
);
  assign sum_o  = {1'b0, a_i} + {1'b0, b_i};
  assign diff_o = a_i - b_i;
  assign lt_o   = a_i < b_i;
  assign eq_o   = a_i == b_i;
endmodule

// File: rtl/xor_locked_dp.sv
module xor_locked_dp #(
  parameter int               W           = 32,
  parameter int               KEY_W       = 64,
  parameter logic [KEY_W-1:0] CORRECT_KEY = 64'hC3A5_0F96_5A3C_E187
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [KEY_W-1:0] key_i,
  output logic [W:0]       sum_o,
  output logic [W-1:0]     diff_o,
  output logic             lt_o,
  output logic             eq_o,
  output logic [W:0]       ref_sum_o,
  output logic [W-1:0]     ref_diff_o,
  output logic             ref_lt_o,
  output logic             ref_eq_o
);
  localparam int N_ADD  = W + 1;
  localparam int N_SUB  = KEY_W - N_ADD;
  localparam int NUM_PO = 2 * W + 3;
  localparam logic [N_ADD-1:0] ADD_KEY = CORRECT_KEY[N_ADD-1:0];
  localparam logic [N_SUB-1:0] SUB_KEY = CORRECT_KEY[KEY_W-1:N_ADD];

  if (KEY_W < 64 || KEY_W > NUM_PO || N_SUB < 1 || N_SUB > W) begin : g_bad_params
    $error("xor_locked_dp: key width must be >= 64, <= output count, and cover the adder");
  end

  logic sub_cout;

  dp_locked_addsub #(.W(W), .N_LOCK(N_ADD), .SUB(1'b0), .GOOD_KEY(ADD_KEY)) u_add (
    .a_i(a_i), .b_i(b_i), .key_i(key_i[N_ADD-1:0]),
    .res_o(sum_o[W-1:0]), .cout_o(sum_o[W])
  );

  dp_locked_addsub #(.W(W), .N_LOCK(N_SUB), .SUB(1'b1), .GOOD_KEY(SUB_KEY)) u_sub (
    .a_i(a_i), .b_i(b_i), .key_i(key_i[KEY_W-1:N_ADD]),
    .res_o(diff_o), .cout_o(sub_cout)
  );

  assign lt_o = ~sub_cout;
  assign eq_o = (a_i == b_i);

  dp_ref #(.W(W)) u_ref (
    .a_i(a_i), .b_i(b_i), .sum_o(ref_sum_o), .diff_o(ref_diff_o),
    .lt_o(ref_lt_o), .eq_o(ref_eq_o)
  );
endmodule

// File: rtl/dp_lock_chk.sv
module dp_lock_chk #(
  parameter int               W           = 32,
  parameter int               KEY_W       = 64,
  parameter logic [KEY_W-1:0] CORRECT_KEY = '0
) (
  input logic [W-1:0]     a_i,
  input logic [W-1:0]     b_i,
  input logic [KEY_W-1:0] key_i,
  input logic [W:0]       sum_o,
  input logic [W-1:0]     diff_o,
  input logic             lt_o,
  input logic             eq_o,
  input logic [W:0]       ref_sum_o,
  input logic [W-1:0]     ref_diff_o,
  input logic             ref_lt_o,
  input logic             ref_eq_o
);
  localparam int N_ADD = W + 1;
  localparam int N_SUB = KEY_W - N_ADD;

  logic [KEY_W-1:0] bad;
  logic [W-1:0]     dmask;

  always_comb begin
    bad   = key_i ^ CORRECT_KEY;
    dmask = '0;
    dmask[N_SUB-1:0] = bad[KEY_W-1:N_ADD];

    if (bad == '0) begin
      p_match_ref_r1: assert (sum_o == ref_sum_o && diff_o == ref_diff_o)
        else $error("R1: correct key but locked result differs from reference");
    end
    p_sum_private_r2: assert ((sum_o ^ ref_sum_o) == bad[N_ADD-1:0])
      else $error("R2: sum mismatch pattern differs from wrong key bits");
    p_diff_private_r3: assert ((diff_o ^ ref_diff_o) == dmask)
      else $error("R3: difference mismatch pattern differs from wrong key bits");
    p_cmp_keyfree_r4: assert (lt_o == ref_lt_o && eq_o == ref_eq_o)
      else $error("R4: comparator flags depend on key");
    p_ref_consistent_r5: assert (ref_eq_o == (ref_diff_o == '0))
      else $error("R5: reference equality disagrees with reference difference");
  end
endmodule

bind xor_locked_dp dp_lock_chk #(.W(W), .KEY_W(KEY_W), .CORRECT_KEY(CORRECT_KEY)) u_chk (
  .a_i(a_i), .b_i(b_i), .key_i(key_i), .sum_o(sum_o), .diff_o(diff_o),
  .lt_o(lt_o), .eq_o(eq_o), .ref_sum_o(ref_sum_o), .ref_diff_o(ref_diff_o),
  .ref_lt_o(ref_lt_o), .ref_eq_o(ref_eq_o)
);

// File: tb/xor_locked_dp_test.sv
`timescale 1ns/1ps
module xor_locked_dp_test;
  localparam int          W     = 32;
  localparam int          KEY_W = 64;
  localparam logic [63:0] GOOD  = 64'h9E37_79B9_7F4A_7C15;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0]     a = '0, b = '0;
  logic [KEY_W-1:0] key = GOOD;
  logic [W:0]       sum_o, ref_sum_o;
  logic [W-1:0]     diff_o, ref_diff_o;
  logic             lt_o, eq_o, ref_lt_o, ref_eq_o;

  int n_tests = 0;
  int n_fail  = 0;

  xor_locked_dp #(.W(W), .KEY_W(KEY_W), .CORRECT_KEY(GOOD)) uut (
    .a_i(a), .b_i(b), .key_i(key), .sum_o(sum_o), .diff_o(diff_o),
    .lt_o(lt_o), .eq_o(eq_o), .ref_sum_o(ref_sum_o), .ref_diff_o(ref_diff_o),
    .ref_lt_o(ref_lt_o), .ref_eq_o(ref_eq_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural model: true function, then wrong key bits invert their own result bit
  task automatic run(input logic [W-1:0] av, input logic [W-1:0] bv,
                     input logic [KEY_W-1:0] kv, input string tag);
    longint unsigned tsum, tdiff;
    logic [63:0] wrong, esum, ediff;
    @(posedge clk);
    a = av; b = bv; key = kv;
    @(negedge clk);
    tsum  = longint'(av) + longint'(bv);
    tdiff = (longint'(av) - longint'(bv)) & 64'hFFFF_FFFF;
    wrong = kv ^ GOOD;
    esum  = tsum ^ (wrong & 64'h1_FFFF_FFFF);
    ediff = tdiff ^ (wrong >> 33);
    chk({tag, " sum"},  64'(sum_o),  esum);
    chk({tag, " diff"}, 64'(diff_o), ediff);
    chk("R4 lt/eq keyfree", {62'd0, lt_o, eq_o}, {62'd0, av < bv, av == bv});
    chk("R5 reference", {ref_sum_o, ref_diff_o}, {tsum[32:0], tdiff[31:0]});
    chk("R5 reference flags", {62'd0, ref_lt_o, ref_eq_o}, {62'd0, av < bv, av == bv});
    if (wrong != 0)
      chk("R7 wrong key corrupts output",
          64'((sum_o != ref_sum_o) || (diff_o != ref_diff_o)), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1 corner operands with the correct key
    run('0, '0, GOOD, "R1 zero");
    run('1, '1, GOOD, "R1 max+max");
    run('1, 32'd1, GOOD, "R1 carry out");
    run(32'd5, 32'd5, GOOD, "R1 equal");
    run(32'd3, 32'd9, GOOD, "R1 borrow");
    run(32'd9, 32'd3, GOOD, "R1 no borrow");
    for (int i = 0; i < 200; i++)
      run($urandom, $urandom, GOOD, "R1 random");
    // single wrong key bit, R2 covers adder bits, R3 difference bits
    for (int j = 0; j < KEY_W; j++) begin
      for (int v = 0; v < 4; v++) begin
        if (j <= W) run($urandom, $urandom, GOOD ^ (64'd1 << j), "R2 single flip");
        else        run($urandom, $urandom, GOOD ^ (64'd1 << j), "R3 single flip");
      end
    end
    // R3 top difference bit untouched even with every difference key bit wrong
    run('1, '0, GOOD ^ 64'hFFFF_FFFE_0000_0000, "R3 top bit free");
    // R6 several wrong bits at once: no cancellation
    for (int i = 0; i < 100; i++)
      run($urandom, $urandom, GOOD ^ {$urandom, $urandom}, "R6 multi flip");
    run(32'd7, 32'd7, ~GOOD, "R6 all bits wrong");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule